// File: doc/BRIEF.md
# Chipmode Memory Space Router

This block sits between the CPU's memory request lines and the external memory pins. It decides which device answers each access: the internal boot ROM, the internal 3 KB XRAM, the external code chip (ROM/flash, driven through the program-store strobe) or the external data chip (SRAM, driven through its read/write strobes). The decision depends on the access kind (instruction fetch, data read, data write), on the 16-bit address and on a 2-bit chipmode held in a small register. In that register bit 1 is the program-enable bit and bit 0 is the swap bit.

In two of the four modes the two external chips trade places. The SRAM then holds code and is fetched through an alternate code strobe. The flash is then reached as data memory through the program-store strobe. It is read-only in one of these modes and written through a dedicated flash-write strobe in the other. Selects and strobes are combinational from the current access and the registered mode. The program-enable bit is only accepted while the external program-enable pin is high.

Top module: `mem_space_router`

## Requirements
- R1: After reset the chipmode is 00 (normal). A fetch at any address selects the external code chip with the program-store strobe.
- R2: A chipmode write (cfgWrEn high for one cycle) is stored at the next rising edge. An access made in the same cycle as the write still uses the old mode. Every later access uses the new mode. Without a write the mode holds.
- R3: On a chipmode write, bit 0 of cfgWrData is always stored. Bit 1 is stored as written only when progPin is high in that cycle, and is stored as 0 otherwise.
- R4: In mode 00 the boot ROM is never selected, and every fetch from 0x0000 to 0xFFFF goes to the external code chip with the program-store strobe.
- R5: In modes 00 and 10, data accesses at 0xF400 and above select the XRAM with no external strobe. Data accesses below 0xF400 select the external data chip, with the read strobe for reads and the write strobe for writes.
- R6: In mode 01, a fetch below 0x0200 selects the boot ROM and a fetch at 0xF400 or above selects the XRAM. Any other fetch selects the external data chip with the alternate code strobe.
- R7: In mode 01, every data read selects the external code chip with the program-store strobe. Every data write selects the external code chip with no strobe and raises wrBlocked for that cycle.
- R8: In mode 10, a fetch below 0x0200 selects the boot ROM. Any other fetch, including 0xF400 and above, selects the external code chip with the program-store strobe.
- R9: In mode 11, fetches and data reads map as in mode 01. A data write selects the external code chip with the flash-write strobe, and wrBlocked stays low.
- R10: Each cycle with an access asserts exactly one select and at most one strobe. An idle cycle asserts none. When several request lines are high together, fetch wins over read and read wins over write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Chipmode register write enable |
| cfgWrData | input | 2 | New chipmode: bit 1 program-enable, bit 0 swap |
| progPin | input | 1 | External program-enable pin |
| addr | input | 16 | Access address |
| fetchEn | input | 1 | Instruction fetch request |
| rdEn | input | 1 | Data read request |
| wrEn | input | 1 | Data write request |
| selBoot | output | 1 | Boot ROM selected |
| selXram | output | 1 | Internal XRAM selected |
| selExtCode | output | 1 | External code/flash chip selected |
| selExtData | output | 1 | External data SRAM selected |
| strbPse | output | 1 | Program-store strobe enable |
| strbAlt | output | 1 | Alternate code strobe enable (SRAM as code) |
| strbRd | output | 1 | Data read strobe enable |
| strbWr | output | 1 | Data write strobe enable |
| strbWrFlash | output | 1 | Flash write strobe enable |
| wrBlocked | output | 1 | The current data write is refused |

## Verification
Selects, strobes and wrBlocked are due in the same cycle as the request, with no register on the path. The bench drives a request on the falling edge and samples one nanosecond before the next rising edge. A chipmode change is due one rising edge after the write cycle. The bench therefore checks an access made during the write cycle against the old mapping, and the access made in the following cycle against the new mapping. This covers both sides of the register boundary, including the case where progPin low turns a write of 11 into 01.

// File: rtl/msr_pkg.sv
package msr_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_XRAM   = 2'b01,
    MODE_BOOT   = 2'b10,
    MODE_PROG   = 2'b11
  } chipMode_e;

  // Strobes from mode control to the address datapath
  typedef struct packed {
    logic bootOn;    // low window of code space served by boot ROM
    logic codeSwap;  // external chips trade code/data roles
    logic flashWr;   // data writes reach flash in swapped map
  } modeCtl_t;

endpackage

// File: rtl/mode_ctrl.sv
module mode_ctrl
  import msr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWrEn,
  input  logic [1:0] cfgWrData,
  input  logic       progPin,
  output logic [1:0] modeQ,
  output modeCtl_t   ctl
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= MODE_NORMAL;
    end else if (cfgWrEn) begin
      // program-enable bit only sticks while the pin allows it
      modeQ <= {cfgWrData[1] & progPin, cfgWrData[0]};
    end
  end

  always_comb begin
    ctl = '0;
    unique case (chipMode_e'(modeQ))
      MODE_NORMAL: ctl = '{bootOn: 1'b0, codeSwap: 1'b0, flashWr: 1'b0};
      MODE_XRAM:   ctl = '{bootOn: 1'b1, codeSwap: 1'b1, flashWr: 1'b0};
      MODE_BOOT:   ctl = '{bootOn: 1'b1, codeSwap: 1'b0, flashWr: 1'b0};
      MODE_PROG:   ctl = '{bootOn: 1'b1, codeSwap: 1'b1, flashWr: 1'b1};
      default:     ctl = '0;
    endcase
  end

endmodule

// File: rtl/addr_decode.sv
module addr_decode
  import msr_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter int                BOOT_SIZE = 512,
  parameter logic [ADDR_W-1:0] XRAM_BASE = 16'hF400
) (
  input  modeCtl_t          ctl,
  input  logic [ADDR_W-1:0] addr,
  input  logic              fetchEn,
  input  logic              rdEn,
  input  logic              wrEn,
  output logic              selBoot,
  output logic              selXram,
  output logic              selExtCode,
  output logic              selExtData,
  output logic              strbPse,
  output logic              strbAlt,
  output logic              strbRd,
  output logic              strbWr,
  output logic              strbWrFlash,
  output logic              wrBlocked
);

  localparam logic [ADDR_W-1:0] BOOT_END = ADDR_W'(BOOT_SIZE);

  logic inBoot, inXram, doFetch, doRd, doWr;

  assign inBoot  = addr < BOOT_END;
  assign inXram  = addr >= XRAM_BASE;
  assign doFetch = fetchEn;
  assign doRd    = rdEn & ~fetchEn;
  assign doWr    = wrEn & ~fetchEn & ~rdEn;

  always_comb begin
    selBoot     = 1'b0;
    selXram     = 1'b0;
    selExtCode  = 1'b0;
    selExtData  = 1'b0;
    strbPse     = 1'b0;
    strbAlt     = 1'b0;
    strbRd      = 1'b0;
    strbWr      = 1'b0;
    strbWrFlash = 1'b0;
    wrBlocked   = 1'b0;
    if (doFetch) begin
      if (ctl.bootOn && inBoot) begin
        selBoot = 1'b1;
      end else if (ctl.codeSwap && inXram) begin
        selXram = 1'b1;
      end else if (ctl.codeSwap) begin
        selExtData = 1'b1;
        strbAlt    = 1'b1;
      end else begin
        selExtCode = 1'b1;
        strbPse    = 1'b1;
      end
    end else if (doRd) begin
      if (ctl.codeSwap) begin
        selExtCode = 1'b1;
        strbPse    = 1'b1;
      end else if (inXram) begin
        selXram = 1'b1;
      end else begin
        selExtData = 1'b1;
        strbRd     = 1'b1;
      end
    end else if (doWr) begin
      if (ctl.codeSwap) begin
        selExtCode  = 1'b1;
        strbWrFlash = ctl.flashWr;
        wrBlocked   = ~ctl.flashWr;
      end else if (inXram) begin
        selXram = 1'b1;
      end else begin
        selExtData = 1'b1;
        strbWr     = 1'b1;
      end
    end
  end

endmodule

// File: rtl/mem_space_router.sv
module mem_space_router
  import msr_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter int                BOOT_SIZE = 512,
  parameter logic [ADDR_W-1:0] XRAM_BASE = 16'hF400
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgWrData,
  input  logic              progPin,
  input  logic [ADDR_W-1:0] addr,
  input  logic              fetchEn,
  input  logic              rdEn,
  input  logic              wrEn,
  output logic              selBoot,
  output logic              selXram,
  output logic              selExtCode,
  output logic              selExtData,
  output logic              strbPse,
  output logic              strbAlt,
  output logic              strbRd,
  output logic              strbWr,
  output logic              strbWrFlash,
  output logic              wrBlocked
);

  logic [1:0] modeQ;
  modeCtl_t   ctl;

  mode_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgWrData (cfgWrData),
    .progPin   (progPin),
    .modeQ     (modeQ),
    .ctl       (ctl)
  );

  addr_decode #(
    .ADDR_W    (ADDR_W),
    .BOOT_SIZE (BOOT_SIZE),
    .XRAM_BASE (XRAM_BASE)
  ) u_dec (
    .ctl         (ctl),
    .addr        (addr),
    .fetchEn     (fetchEn),
    .rdEn        (rdEn),
    .wrEn        (wrEn),
    .selBoot     (selBoot),
    .selXram     (selXram),
    .selExtCode  (selExtCode),
    .selExtData  (selExtData),
    .strbPse     (strbPse),
    .strbAlt     (strbAlt),
    .strbRd      (strbRd),
    .strbWr      (strbWr),
    .strbWrFlash (strbWrFlash),
    .wrBlocked   (wrBlocked)
  );

endmodule

// File: rtl/msr_checker.sv
module msr_checker (
  input logic       clk,
  input logic       rstN,
  input logic       cfgWrEn,
  input logic [1:0] cfgWrData,
  input logic       progPin,
  input logic       fetchEn,
  input logic       rdEn,
  input logic       wrEn,
  input logic [1:0] modeQ,
  input logic       selBoot,
  input logic       selXram,
  input logic       selExtCode,
  input logic       selExtData,
  input logic       strbPse,
  input logic       strbAlt,
  input logic       strbRd,
  input logic       strbWr,
  input logic       strbWrFlash,
  input logic       wrBlocked
);

  logic [3:0] sels;
  logic [4:0] strbs;
  logic       anyReq;

  assign sels   = {selBoot, selXram, selExtCode, selExtData};
  assign strbs  = {strbPse, strbAlt, strbRd, strbWr, strbWrFlash};
  assign anyReq = fetchEn | rdEn | wrEn;

  p_one_sel_r10: assert property (@(posedge clk) disable iff (!rstN)
    anyReq |-> $countones(sels) == 1);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !anyReq |-> (sels == 4'b0 && strbs == 5'b0 && !wrBlocked));

  p_strobe_single_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strbs));

  p_blocked_silent_r7: assert property (@(posedge clk) disable iff (!rstN)
    wrBlocked |-> (strbs == 5'b0 && selExtCode && wrEn));

  p_pin_gate_r3: assert property (@(posedge clk) disable iff (!rstN)
    $past(cfgWrEn && !progPin) |-> !modeQ[1]);

  p_swap_taken_r2: assert property (@(posedge clk) disable iff (!rstN)
    $past(cfgWrEn) |-> modeQ[0] == $past(cfgWrData[0]));

  p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$past(cfgWrEn) |-> $stable(modeQ));

  p_no_boot_normal_r4: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == 2'b00) |-> !selBoot);

  p_alt_is_fetch_r6: assert property (@(posedge clk) disable iff (!rstN)
    strbAlt |-> (selExtData && fetchEn));

endmodule

bind mem_space_router msr_checker u_chk (.*);

// File: tb/tb_mem_space_router.sv
module tb_mem_space_router;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [1:0]  cfgWrData = 2'b00;
  logic        progPin = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic        fetchEn = 1'b0, rdEn = 1'b0, wrEn = 1'b0;
  logic selBoot, selXram, selExtCode, selExtData;
  logic strbPse, strbAlt, strbRd, strbWr, strbWrFlash, wrBlocked;

  int checks = 0;
  int failures = 0;

  localparam logic [9:0] B_BOOT = 10'b1000000000;
  localparam logic [9:0] B_XRAM = 10'b0100000000;
  localparam logic [9:0] B_ECOD = 10'b0010000000;
  localparam logic [9:0] B_EDAT = 10'b0001000000;
  localparam logic [9:0] B_PSE  = 10'b0000100000;
  localparam logic [9:0] B_ALT  = 10'b0000010000;
  localparam logic [9:0] B_RD   = 10'b0000001000;
  localparam logic [9:0] B_WR   = 10'b0000000100;
  localparam logic [9:0] B_WF   = 10'b0000000010;
  localparam logic [9:0] B_BLK  = 10'b0000000001;

  always #4 clk = ~clk;

  mem_space_router dut (.*);

  function automatic logic [9:0] outs();
    return {selBoot, selXram, selExtCode, selExtData, strbPse,
            strbAlt, strbRd, strbWr, strbWrFlash, wrBlocked};
  endfunction

  task automatic check(string req, string what, logic [9:0] exp);
    checks++;
    if (outs() !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, outs(), exp);
    end
  endtask

  // kind: 0 idle, 1 fetch, 2 read, 3 write, 4 fetch+read, 5 read+write
  task automatic access(string req, int kind, logic [15:0] a, logic [9:0] exp);
    @(negedge clk);
    addr    = a;
    fetchEn = (kind == 1 || kind == 4);
    rdEn    = (kind == 2 || kind == 4 || kind == 5);
    wrEn    = (kind == 3 || kind == 5);
    #3;
    check(req, $sformatf("kind %0d addr %h", kind, a), exp);
    @(negedge clk);
    fetchEn = 1'b0; rdEn = 1'b0; wrEn = 1'b0;
  endtask

  // Write the mode while fetching; that fetch must still see the old mode.
  task automatic setMode(logic [1:0] m, logic pin, logic [15:0] a, logic [9:0] expOld);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrData = m; progPin = pin;
    addr = a; fetchEn = 1'b1;
    #3;
    check("R2", "fetch in write cycle uses old mode", expOld);
    @(negedge clk);
    cfgWrEn = 1'b0; fetchEn = 1'b0; progPin = 1'b0;
  endtask

  task automatic testReset();
    access("R1", 0, 16'h0000, 10'b0);
    access("R1", 1, 16'h0000, B_ECOD | B_PSE);
  endtask

  task automatic testNormal();
    access("R4", 1, 16'h0100, B_ECOD | B_PSE);
    access("R4", 1, 16'hFFFF, B_ECOD | B_PSE);
    access("R5", 2, 16'hF400, B_XRAM);
    access("R5", 2, 16'hF3FF, B_EDAT | B_RD);
    access("R5", 3, 16'h1234, B_EDAT | B_WR);
    access("R5", 3, 16'hFFFF, B_XRAM);
  endtask

  task automatic testPinGate();
    // 11 written with pin low is stored as 01
    setMode(2'b11, 1'b0, 16'h0000, B_ECOD | B_PSE);
    access("R3", 1, 16'h0000, B_BOOT);
    access("R3", 3, 16'h0400, B_ECOD | B_BLK);
  endtask

  task automatic testXram();
    access("R6", 1, 16'h01FF, B_BOOT);
    access("R6", 1, 16'h0200, B_EDAT | B_ALT);
    access("R6", 1, 16'hF3FF, B_EDAT | B_ALT);
    access("R6", 1, 16'hF400, B_XRAM);
    access("R7", 2, 16'h0000, B_ECOD | B_PSE);
    access("R7", 2, 16'hF800, B_ECOD | B_PSE);
    access("R7", 3, 16'h8000, B_ECOD | B_BLK);
    access("R10", 0, 16'h8000, 10'b0);
  endtask

  task automatic testBoot();
    setMode(2'b10, 1'b1, 16'h0000, B_BOOT);
    access("R8", 1, 16'h0000, B_BOOT);
    access("R8", 1, 16'h0200, B_ECOD | B_PSE);
    access("R8", 1, 16'hF400, B_ECOD | B_PSE);
    access("R5", 2, 16'hF400, B_XRAM);
    access("R5", 3, 16'h0010, B_EDAT | B_WR);
  endtask

  task automatic testProg();
    setMode(2'b11, 1'b1, 16'h0000, B_BOOT);
    access("R9", 1, 16'h0300, B_EDAT | B_ALT);
    access("R9", 1, 16'hF400, B_XRAM);
    access("R9", 2, 16'h0300, B_ECOD | B_PSE);
    access("R9", 3, 16'h0300, B_ECOD | B_WF);
    access("R10", 4, 16'h0300, B_EDAT | B_ALT);
    access("R10", 5, 16'h0300, B_ECOD | B_PSE);
  endtask

  task automatic testBackToNormal();
    // bit 1 requested with pin low: 10 stored as 00
    setMode(2'b10, 1'b0, 16'h0300, B_EDAT | B_ALT);
    access("R3", 1, 16'h0000, B_ECOD | B_PSE);
    access("R2", 1, 16'h0000, B_ECOD | B_PSE);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    testReset();
    testNormal();
    testPinGate();
    testXram();
    testBoot();
    testProg();
    testBackToNormal();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule